// File: doc/BRIEF.md
# Chip-Select Window Decoder

This block sits between a processor address path and up to eight external memory chip selects. Each chip select owns one configuration word with three fields: a window base, a window mask and an enable bit. Each cycle a qualified address is presented. One cycle later the block reports which chip select claims it, as a one-hot vector, and the byte offset of the address inside that window.

Window sizes run from 16 MB to 256 MB. The mask is a 4-bit code. Only codes whose ones fill the mask from its top bit downward are accepted. The all-zero code, meaning the full 256 MB window, is accepted only while a large-window option input is high. A chip select whose mask code is refused at configuration time is blocked and raises a sticky error flag. When windows overlap, the lowest-numbered chip select wins and an overlap flag is raised. A configuration write counts as a reconfiguration only when it changes a stored bit. A write that leaves the stored bits unchanged does not re-run the mask check.

Top module: `cswin_decoder`

## Requirements
- R1: After reset, chip select 0 reads back 0x00000F40 and every other chip select reads back 0x00000F00 (mask 0xF, enabled only for chip select 0). The hit vector, offset, overlap flag and error flag are all zero.
- R2: A configuration write stores only the bits set in 0x00000F7F. Read-back returns the stored word.
- R3: Field layout: bits [5:0] are the base, bit 6 is the enable, bits [11:8] are the mask. A chip select claims address A when A[29:28] equals base[5:4] and every address bit A[27:24] selected by the mask equals the matching base bit. This gives a window of 0x0FFFFFFF & ~(mask << 24), plus one, bytes.
- R4: The reported offset is A[27:0] with the mask-selected bits of A[27:24] cleared, which is A modulo the window size.
- R5: A chip select whose enable bit is clear never claims an address, whatever its other fields hold.
- R6: Mask codes 0x8, 0xC, 0xE and 0xF are legal. Code 0x0 is legal only if the large-window input is high when the reconfiguring write happens. Lowering that input later does not affect a window already accepted.
- R7: A reconfiguring write that sets the enable bit with an illegal mask blocks that chip select until it is reconfigured again, and sets the error flag. The error flag stays set until reset. An illegal mask with the enable bit clear raises no error.
- R8: A write whose masked value equals the stored word changes nothing. The mask check is not re-run, so a blocked chip select stays blocked.
- R9: When several chip selects claim an address, only the lowest-numbered one appears in the hit vector, its offset is reported, and the overlap flag is set. With a single claimant the overlap flag is clear.
- R10: Hit, offset and overlap are registered: they reflect the address and configuration seen at the previous clock edge. They are all zero after a cycle with the address qualifier low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wsel_i | input | 3 | Chip select written |
| cfg_wdata_i | input | 32 | Configuration write data |
| cfg_rsel_i | input | 3 | Chip select read back |
| cfg_rdata_o | output | 32 | Stored configuration of the selected chip select |
| big_win_en_i | input | 1 | Accept mask code 0 (256 MB window) |
| lk_valid_i | input | 1 | Address qualifier |
| lk_addr_i | input | 30 | Address to decode |
| cs_hit_o | output | 8 | One-hot winning chip select |
| win_ofs_o | output | 28 | Offset inside the winning window |
| overlap_o | output | 1 | More than one chip select claimed the address |
| mask_err_o | output | 1 | Sticky illegal-mask flag |

## Verification
Lookups cover every legal window size: 16 MB on chip select 0, 32 MB, 64 MB, 128 MB and a 256 MB window on a chip select whose mask was zero. Each size is probed both just inside and outside its span, which separates the masked compare from a full-field compare and shows whether the offset keeps the right middle bits. Disabled and refused windows are placed at addresses no other window covers, so a stray hit cannot be confused with a legitimate one. Overlap patterns pair a low chip select with a higher one in both the 16 MB and the 64/128 MB cases. The large-window input is toggled around identical and differing writes, which tells a change-qualified remap apart from one that re-checks on every write.

// File: rtl/cswin_pkg.sv
package cswin_pkg;

    localparam int BASE_W    = 6;
    localparam int VALID_BIT = 6;
    localparam int MASK_LSB  = 8;
    localparam int MASK_W    = 4;
    localparam int WIN_LSB   = 24;

    // Bits a configuration word may hold: base, enable, mask
    localparam logic [31:0] KEEP_BITS = 32'h0000_0F7F;
    localparam logic [MASK_W-1:0] FULL_MASK = '1;

    // Legal codes fill the mask from its top bit downward without gaps;
    // the empty code is legal only with the large-window option.
    function automatic logic mask_ok(input logic [MASK_W-1:0] m, input logic big_ok);
        logic ok;
        ok = m[MASK_W-1];
        for (int i = MASK_W - 2; i >= 0; i--) begin
            if (m[i] && !m[i+1]) begin
                ok = 1'b0;
            end
        end
        return ok || ((m == '0) && big_ok);
    endfunction

endpackage

// File: rtl/cswin_slot.sv
module cswin_slot
    import cswin_pkg::*;
#(
    parameter int CFG_W     = 32,
    parameter bit RST_VALID = 1'b0
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [CFG_W-1:0]            wr_data,
    input  logic                        big_ok,
    input  logic [WIN_LSB+BASE_W-1:0]   addr,
    output logic [CFG_W-1:0]            cfg_o,
    output logic                        hit_o,
    output logic [WIN_LSB+MASK_W-1:0]   ofs_o,
    output logic                        bad_set_o
);

    localparam int ADDR_W = WIN_LSB + BASE_W;
    localparam int HI_W   = BASE_W - MASK_W;
    localparam logic [CFG_W-1:0] KEEP    = CFG_W'(KEEP_BITS);
    localparam logic [CFG_W-1:0] RST_CFG = (CFG_W'(FULL_MASK) << MASK_LSB)
                                         | (CFG_W'(RST_VALID) << VALID_BIT);

    typedef struct packed {
        logic [CFG_W-1:0] cfg;
        logic             bad;
    } slot_t;

    slot_t s_d, s_q;

    logic              changed;
    logic              new_valid;
    logic [MASK_W-1:0] new_mask;
    logic              cur_valid;
    logic [MASK_W-1:0] cur_mask;
    logic [BASE_W-1:0] cur_base;
    logic              hi_match;
    logic              mid_match;

    always_comb begin
        cur_valid = s_q.cfg[VALID_BIT];
        cur_mask  = s_q.cfg[MASK_LSB +: MASK_W];
        cur_base  = s_q.cfg[BASE_W-1:0];
        changed   = |((wr_data ^ s_q.cfg) & KEEP);
        new_valid = wr_data[VALID_BIT];
        new_mask  = wr_data[MASK_LSB +: MASK_W];

        s_d       = s_q;
        bad_set_o = 1'b0;
        if (wr_en && changed) begin
            s_d.cfg   = wr_data & KEEP;
            s_d.bad   = new_valid && !mask_ok(new_mask, big_ok);
            bad_set_o = s_d.bad;
        end

        hi_match  = (addr[ADDR_W-1 -: HI_W] == cur_base[BASE_W-1 -: HI_W]);
        mid_match = (((addr[WIN_LSB +: MASK_W] ^ cur_base[MASK_W-1:0]) & cur_mask) == '0);
        hit_o     = cur_valid && !s_q.bad && hi_match && mid_match;
        ofs_o     = {addr[WIN_LSB +: MASK_W] & ~cur_mask, addr[WIN_LSB-1:0]};
        cfg_o     = s_q.cfg;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{cfg: RST_CFG, bad: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/cswin_pick.sv
module cswin_pick #(
    parameter int N     = 8,
    parameter int OFS_W = 28
) (
    input  logic                      req,
    input  logic [N-1:0]              hits,
    input  logic [N-1:0][OFS_W-1:0]   ofs_in,
    output logic [N-1:0]              sel_o,
    output logic [OFS_W-1:0]          ofs_o,
    output logic                      ovl_o
);

    logic [N-1:0] live;
    logic         found;

    always_comb begin
        live  = hits & {N{req}};
        sel_o = '0;
        ofs_o = '0;
        found = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (live[i] && !found) begin
                found    = 1'b1;
                sel_o[i] = 1'b1;
                ofs_o    = ofs_in[i];
            end
        end
        ovl_o = |(live & (live - N'(1)));
    end

endmodule

// File: rtl/cswin_decoder.sv
module cswin_decoder
    import cswin_pkg::*;
#(
    parameter  int NUM_CS = 8,
    parameter  int CFG_W  = 32,
    localparam int SEL_W  = $clog2(NUM_CS),
    localparam int ADDR_W = WIN_LSB + BASE_W,
    localparam int OFS_W  = WIN_LSB + MASK_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we_i,
    input  logic [SEL_W-1:0]    cfg_wsel_i,
    input  logic [CFG_W-1:0]    cfg_wdata_i,
    input  logic [SEL_W-1:0]    cfg_rsel_i,
    output logic [CFG_W-1:0]    cfg_rdata_o,
    input  logic                big_win_en_i,
    input  logic                lk_valid_i,
    input  logic [ADDR_W-1:0]   lk_addr_i,
    output logic [NUM_CS-1:0]   cs_hit_o,
    output logic [OFS_W-1:0]    win_ofs_o,
    output logic                overlap_o,
    output logic                mask_err_o
);

    typedef struct packed {
        logic [NUM_CS-1:0] hit;
        logic [OFS_W-1:0]  ofs;
        logic              ovl;
        logic              err;
    } out_t;

    logic [NUM_CS-1:0][CFG_W-1:0] cfg_all;
    logic [NUM_CS-1:0][OFS_W-1:0] slot_ofs;
    logic [NUM_CS-1:0]            slot_hit;
    logic [NUM_CS-1:0]            bad_set;
    logic [NUM_CS-1:0]            pick_sel;
    logic [OFS_W-1:0]             pick_ofs;
    logic                         pick_ovl;

    out_t o_d, o_q;

    for (genvar g = 0; g < NUM_CS; g++) begin : g_slot
        cswin_slot #(
            .CFG_W     (CFG_W),
            .RST_VALID (g == 0)
        ) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (cfg_we_i && (cfg_wsel_i == SEL_W'(g))),
            .wr_data   (cfg_wdata_i),
            .big_ok    (big_win_en_i),
            .addr      (lk_addr_i),
            .cfg_o     (cfg_all[g]),
            .hit_o     (slot_hit[g]),
            .ofs_o     (slot_ofs[g]),
            .bad_set_o (bad_set[g])
        );
    end

    cswin_pick #(
        .N     (NUM_CS),
        .OFS_W (OFS_W)
    ) u_pick (
        .req    (lk_valid_i),
        .hits   (slot_hit),
        .ofs_in (slot_ofs),
        .sel_o  (pick_sel),
        .ofs_o  (pick_ofs),
        .ovl_o  (pick_ovl)
    );

    always_comb begin
        o_d.hit = pick_sel;
        o_d.ofs = pick_ofs;
        o_d.ovl = pick_ovl;
        o_d.err = o_q.err | (|bad_set);

        cfg_rdata_o = '0;
        for (int i = 0; i < NUM_CS; i++) begin
            if (cfg_rsel_i == SEL_W'(i)) begin
                cfg_rdata_o = cfg_all[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign cs_hit_o   = o_q.hit;
    assign win_ofs_o  = o_q.ofs;
    assign overlap_o  = o_q.ovl;
    assign mask_err_o = o_q.err;

endmodule

// File: rtl/cswin_decoder_chk.sv
module cswin_decoder_chk
    import cswin_pkg::*;
#(
    parameter int NUM_CS = 8,
    parameter int CFG_W  = 32,
    parameter int OFS_W  = 28
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         lk_valid_i,
    input logic [NUM_CS-1:0]            cs_hit_o,
    input logic [OFS_W-1:0]             win_ofs_o,
    input logic                         overlap_o,
    input logic                         mask_err_o,
    input logic [CFG_W-1:0]             cfg_rdata_o,
    input logic [NUM_CS-1:0][CFG_W-1:0] cfg_all
);

    localparam logic [CFG_W-1:0] KEEP = CFG_W'(KEEP_BITS);

    AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cs_hit_o)); // R9

    AST_OVERLAP_HAS_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
        overlap_o |-> (cs_hit_o != '0)); // R9

    AST_IDLE_CLEARS_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid_i |=> (cs_hit_o == '0 && !overlap_o && win_ofs_o == '0)); // R10

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        mask_err_o |=> mask_err_o); // R7

    AST_READBACK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata_o & ~KEEP) == '0); // R2

    for (genvar g = 0; g < NUM_CS; g++) begin : g_en
        AST_DISABLED_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
            !cfg_all[g][VALID_BIT] |=> !cs_hit_o[g]); // R5
    end

endmodule

bind cswin_decoder cswin_decoder_chk #(
    .NUM_CS (NUM_CS),
    .CFG_W  (CFG_W),
    .OFS_W  (OFS_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .lk_valid_i  (lk_valid_i),
    .cs_hit_o    (cs_hit_o),
    .win_ofs_o   (win_ofs_o),
    .overlap_o   (overlap_o),
    .mask_err_o  (mask_err_o),
    .cfg_rdata_o (cfg_rdata_o),
    .cfg_all     (cfg_all)
);

// File: tb/cswin_decoder_tb_top.sv
module cswin_decoder_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_wsel = '0;
    logic [31:0] cfg_wdata = '0;
    logic [2:0]  cfg_rsel = '0;
    logic [31:0] cfg_rdata;
    logic        big_en = 1'b0;
    logic        lk_valid = 1'b0;
    logic [29:0] lk_addr = '0;
    logic [7:0]  cs_hit;
    logic [27:0] win_ofs;
    logic        overlap;
    logic        mask_err;

    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    string phase = "R1";

    always #10 clk = ~clk;

    cswin_decoder dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_we_i     (cfg_we),
        .cfg_wsel_i   (cfg_wsel),
        .cfg_wdata_i  (cfg_wdata),
        .cfg_rsel_i   (cfg_rsel),
        .cfg_rdata_o  (cfg_rdata),
        .big_win_en_i (big_en),
        .lk_valid_i   (lk_valid),
        .lk_addr_i    (lk_addr),
        .cs_hit_o     (cs_hit),
        .win_ofs_o    (win_ofs),
        .overlap_o    (overlap),
        .mask_err_o   (mask_err)
    );

    // ---------------- behavioural reference model ----------------
    logic [31:0] m_cfg [8];
    bit          m_bad [8];
    bit          m_err = 1'b0;
    logic [7:0]  exp_hit = '0;
    logic [27:0] exp_ofs = '0;
    logic        exp_ovl = 1'b0;
    logic        exp_err = 1'b0;
    int          hq[$];
    longint      a_l;
    longint      sz;
    logic [3:0]  wm;
    bit          legal;

    function automatic longint win_size(logic [3:0] m);
        return (64'h0FFF_FFFF & ~(longint'(m) << 24)) + 1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) begin
                m_cfg[i] = (i == 0) ? 32'h0000_0F40 : 32'h0000_0F00;
                m_bad[i] = 1'b0;
            end
            m_err = 1'b0;
            exp_hit = '0; exp_ofs = '0; exp_ovl = 1'b0; exp_err = 1'b0;
        end else begin
            hq.delete();
            exp_hit = '0; exp_ofs = '0; exp_ovl = 1'b0;
            if (lk_valid) begin
                a_l = longint'(lk_addr);
                for (int i = 0; i < 8; i++) begin
                    if (m_cfg[i][6] && !m_bad[i]) begin
                        sz = win_size(m_cfg[i][11:8]);
                        if ((a_l & ~(sz - 1)) == ((longint'(m_cfg[i][5:0]) << 24) & ~(sz - 1)))
                            hq.push_back(i);
                    end
                end
                if (hq.size() > 0) begin
                    exp_hit = 8'd1 << hq[0];
                    exp_ofs = 28'(a_l % win_size(m_cfg[hq[0]][11:8]));
                    exp_ovl = (hq.size() > 1);
                end
            end
            if (cfg_we && (((cfg_wdata ^ m_cfg[cfg_wsel]) & 32'h0000_0F7F) != 0)) begin
                m_cfg[cfg_wsel] = cfg_wdata & 32'h0000_0F7F;
                wm = cfg_wdata[11:8];
                legal = (wm == 4'h8) || (wm == 4'hC) || (wm == 4'hE) || (wm == 4'hF)
                        || (wm == 4'h0 && big_en);
                m_bad[cfg_wsel] = cfg_wdata[6] && !legal;
                if (m_bad[cfg_wsel]) m_err = 1'b1;
            end
            exp_err = m_err;
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            checks++;
            if (cs_hit !== exp_hit || win_ofs !== exp_ofs || overlap !== exp_ovl || mask_err !== exp_err) begin
                errors++;
                $display("FAIL %s model compare: hit %h/%h ofs %h/%h ovl %b/%b err %b/%b (actual/expected)",
                         phase, cs_hit, exp_hit, win_ofs, exp_ofs, overlap, exp_ovl, mask_err, exp_err);
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] sel, logic [31:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wsel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(logic [2:0] sel, logic [31:0] exp, string tag);
        @(negedge clk);
        cfg_rsel = sel;
        #1;
        chk(tag, "readback", cfg_rdata, exp);
    endtask

    task automatic look(logic v, logic [29:0] a, logic [7:0] eh, logic [27:0] eo, logic eov, string tag);
        @(negedge clk);
        lk_valid = v; lk_addr = a;
        @(negedge clk);
        chk(tag, "hit", 32'(cs_hit), 32'(eh));
        chk(tag, "offset", 32'(win_ofs), 32'(eo));
        chk(tag, "overlap", 32'(overlap), 32'(eov));
        lk_valid = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog expired in phase %s", phase);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        phase = "R1";
        chk("R1", "hit after reset", 32'(cs_hit), 32'h0);
        chk("R1", "error after reset", 32'(mask_err), 32'h0);
        rd(3'd0, 32'h0000_0F40, "R1");
        rd(3'd3, 32'h0000_0F00, "R1");

        phase = "R3";
        look(1'b1, 30'h0012_3456, 8'h01, 28'h012_3456, 1'b0, "R3");
        look(1'b1, 30'h0100_0000, 8'h00, 28'h0, 1'b0, "R3");

        phase = "R2";
        wr(3'd1, 32'hFFFF_EE45);
        rd(3'd1, 32'h0000_0E45, "R2");
        wr(3'd2, 32'h0000_0FC8);
        rd(3'd2, 32'h0000_0F48, "R2");

        phase = "R4";
        look(1'b1, 30'h0512_3456, 8'h02, 28'h112_3456, 1'b0, "R4");
        look(1'b1, 30'h0612_3456, 8'h00, 28'h0, 1'b0, "R3");
        look(1'b1, 30'h08AB_CDEF, 8'h04, 28'h0AB_CDEF, 1'b0, "R4");

        phase = "R5";
        wr(3'd3, 32'h0000_0303);
        chk("R7", "no error for disabled slot", 32'(mask_err), 32'h0);
        look(1'b1, 30'h0300_0000, 8'h00, 28'h0, 1'b0, "R5");

        phase = "R7";
        wr(3'd4, 32'h0000_0564);
        chk("R7", "error raised", 32'(mask_err), 32'h1);
        look(1'b1, 30'h2400_0000, 8'h00, 28'h0, 1'b0, "R7");

        phase = "R6";
        wr(3'd5, 32'h0000_0070);
        look(1'b1, 30'h3ABC_DEF0, 8'h00, 28'h0, 1'b0, "R6");
        big_en = 1'b1;
        phase = "R8";
        wr(3'd5, 32'h0000_0070);
        look(1'b1, 30'h3ABC_DEF0, 8'h00, 28'h0, 1'b0, "R8");
        wr(3'd5, 32'hFFFF_F070);
        look(1'b1, 30'h3ABC_DEF0, 8'h00, 28'h0, 1'b0, "R8");
        phase = "R6";
        wr(3'd5, 32'h0000_0071);
        look(1'b1, 30'h3ABC_DEF0, 8'h20, 28'hABC_DEF0, 1'b0, "R6");
        big_en = 1'b0;
        look(1'b1, 30'h3000_0004, 8'h20, 28'h000_0004, 1'b0, "R6");

        phase = "R7";
        wr(3'd4, 32'h0000_0C64);
        look(1'b1, 30'h2700_0010, 8'h10, 28'h300_0010, 1'b0, "R7");
        chk("R7", "error stays set", 32'(mask_err), 32'h1);

        phase = "R9";
        wr(3'd6, 32'h0000_0860);
        look(1'b1, 30'h2700_0010, 8'h10, 28'h300_0010, 1'b1, "R9");
        look(1'b1, 30'h2100_0000, 8'h40, 28'h100_0000, 1'b0, "R9");
        wr(3'd7, 32'h0000_0840);
        look(1'b1, 30'h0012_3456, 8'h01, 28'h012_3456, 1'b1, "R9");

        phase = "R10";
        look(1'b0, 30'h0012_3456, 8'h00, 28'h0, 1'b0, "R10");

        phase = "R1";
        @(negedge clk);
        #2 rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "error cleared by reset", 32'(mask_err), 32'h0);
        rd(3'd4, 32'h0000_0F00, "R1");
        look(1'b1, 30'h2700_0010, 8'h00, 28'h0, 1'b0, "R1");
        look(1'b1, 30'h0012_3456, 8'h01, 28'h012_3456, 1'b0, "R1");

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule